// File: doc/BRIEF.md
# Forwarded-Clock Sample Receiver

This block sits at the receiving end of a byte-wide source-synchronous link. The sender drives an 8-bit data bus and a forwarded clock, and the forwarded clock toggles only while data is valid. No strobe, frame marker or handshake travels with it. The receiver runs on its own continuous clock, which is faster than the forwarded clock. It brings the forwarded clock and the data bus into its domain through equal-depth register chains. It then watches the synchronized clock for rising edges and treats each edge as one valid byte.

Each captured byte is shifted into a 48-bit register. When the sixth byte of a sample arrives, the block splits the register into a 24-bit I word and a 24-bit Q word, drives them out and raises a single-cycle valid pulse. A watchdog on the gap between edges throws away a partly collected sample when the sender stops in the middle of one. This keeps the next sample from being misaligned.

Top module: `gclk_sample_rx`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and i_word_o and q_word_o are all zeros until the first complete sample.
- R2: A byte is taken only on a rising edge of the synchronized forwarded clock. Changes on fdata_i while fclk_i stays low produce no capture and no output change.
- R3: The captured byte is the value present on fdata_i at the receiver clock edge where fclk_i is first sampled high. The data path has the same register depth as the clock path.
- R4: Six captures form one sample. Captures 1 to 3 are the I word most significant byte first (bits 23:16, 15:8, 7:0), and captures 4 to 6 are the Q word in the same order.
- R5: valid_o is high for exactly one receiver cycle per completed sample. It rises on the third receiver rising edge counted from the edge that first samples fclk_i high for the sixth byte.
- R6: i_word_o and q_word_o change only together with a valid_o pulse and hold their values otherwise.
- R7: If IDLE_LIMIT (default 16) receiver cycles pass with no forwarded-clock edge while a sample is partly collected, the partial bytes are dropped and the next edge starts a new sample. Shorter gaps keep the partial sample.
- R8: A forwarded clock held high for many receiver cycles counts as one byte, not several.
- R9: Samples sent back to back with no gap are each delivered with correct content and their own valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Continuous receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_i | input | 1 | Gated forwarded clock from the sender |
| fdata_i | input | 8 | Forwarded data byte |
| i_word_o | output | 24 | Reassembled I word |
| q_word_o | output | 24 | Reassembled Q word |
| valid_o | output | 1 | One-cycle pulse when a new I/Q pair is on the outputs |

## Verification
The bench drives each forwarded-clock rise at a falling receiver edge. It then counts three rising edges: two synchronizer stages and one capture register. valid_o and the new words are due after the third rising edge, so the bench samples them at the falling edge that follows it. It samples again one falling edge later to confirm that the pulse has ended and the words hold. For every byte that is not the sixth, the same third-edge sample expects valid_o low. This is how a dropped or double-counted byte shows up as a premature or missing pulse.

// File: rtl/gclk_rx_pkg.sv
package gclk_rx_pkg;
  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_WORD_W     = 24;
  localparam int unsigned DEF_SYNC_DEPTH = 2;
  localparam int unsigned DEF_IDLE_LIMIT = 16;
endpackage

// File: rtl/gclk_rx_sync.sv
module gclk_rx_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/gclk_rx_edge.sv
module gclk_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/gclk_rx_assemble.sv
module gclk_rx_assemble #(
  parameter int unsigned BYTE_W     = gclk_rx_pkg::DEF_BYTE_W,
  parameter int unsigned WORD_W     = gclk_rx_pkg::DEF_WORD_W,
  parameter int unsigned IDLE_LIMIT = gclk_rx_pkg::DEF_IDLE_LIMIT,
  localparam int unsigned BYTES     = 2 * (WORD_W / BYTE_W),
  localparam int unsigned SH_W      = 2 * WORD_W,
  localparam int unsigned CNT_W     = $clog2(BYTES),
  localparam int unsigned IDLE_W    = $clog2(IDLE_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] i_word_o,
  output logic [WORD_W-1:0] q_word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [IDLE_W-1:0] idle_cnt_o
);
  logic [SH_W-1:0]   shreg_q, shift_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;

  assign shift_nx = {shreg_q[SH_W-BYTE_W-1:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      idle_q   <= '0;
      i_word_o <= '0;
      q_word_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        shreg_q <= shift_nx;
        idle_q  <= '0;
        if (cnt_q == CNT_W'(BYTES - 1)) begin
          cnt_q    <= '0;
          i_word_o <= shift_nx[SH_W-1:WORD_W];
          q_word_o <= shift_nx[WORD_W-1:0];
          valid_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q != '0) begin
        // sender stalled mid-sample: drop the partial bytes
        if (idle_q == IDLE_W'(IDLE_LIMIT - 1)) begin
          cnt_q  <= '0;
          idle_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  assign byte_cnt_o = cnt_q;
  assign idle_cnt_o = idle_q;
endmodule

// File: rtl/gclk_sample_rx.sv
module gclk_sample_rx #(
  parameter int unsigned BYTE_W     = gclk_rx_pkg::DEF_BYTE_W,
  parameter int unsigned WORD_W     = gclk_rx_pkg::DEF_WORD_W,
  parameter int unsigned SYNC_DEPTH = gclk_rx_pkg::DEF_SYNC_DEPTH,
  parameter int unsigned IDLE_LIMIT = gclk_rx_pkg::DEF_IDLE_LIMIT,
  localparam int unsigned BYTES     = 2 * (WORD_W / BYTE_W),
  localparam int unsigned CNT_W     = $clog2(BYTES),
  localparam int unsigned IDLE_W    = $clog2(IDLE_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fclk_i,
  input  logic [BYTE_W-1:0] fdata_i,
  output logic [WORD_W-1:0] i_word_o,
  output logic [WORD_W-1:0] q_word_o,
  output logic              valid_o
);
  logic              fclk_s;
  logic [BYTE_W-1:0] fdata_s;
  logic              cap_edge;
  logic [CNT_W-1:0]  byte_cnt;
  logic [IDLE_W-1:0] idle_cnt;

  gclk_rx_sync #(.WIDTH(1), .DEPTH(SYNC_DEPTH)) u_sync_clk (
    .clk_i, .rst_ni, .d_i(fclk_i), .q_o(fclk_s)
  );

  // equal depth keeps the byte aligned with the detected edge
  gclk_rx_sync #(.WIDTH(BYTE_W), .DEPTH(SYNC_DEPTH)) u_sync_data (
    .clk_i, .rst_ni, .d_i(fdata_i), .q_o(fdata_s)
  );

  gclk_rx_edge u_edge (
    .clk_i, .rst_ni, .lvl_i(fclk_s), .rise_o(cap_edge)
  );

  gclk_rx_assemble #(
    .BYTE_W(BYTE_W), .WORD_W(WORD_W), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_asm (
    .clk_i, .rst_ni,
    .cap_i(cap_edge), .byte_i(fdata_s),
    .i_word_o, .q_word_o, .valid_o,
    .byte_cnt_o(byte_cnt), .idle_cnt_o(idle_cnt)
  );
endmodule

// File: rtl/gclk_sample_rx_chk.sv
module gclk_sample_rx_chk #(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned BYTES      = 6,
  parameter int unsigned IDLE_LIMIT = 16,
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned IDLE_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_edge,
  input logic              valid_o,
  input logic [WORD_W-1:0] i_word_o,
  input logic [WORD_W-1:0] q_word_o,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [IDLE_W-1:0] idle_cnt
);
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_words_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_word_o) && $stable(q_word_o)));

  assert_valid_after_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(cap_edge));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt < CNT_W'(BYTES));

  assert_idle_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cnt < IDLE_W'(IDLE_LIMIT));

  assert_idle_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_edge |=> (idle_cnt == '0));
endmodule

bind gclk_sample_rx gclk_sample_rx_chk #(
  .WORD_W(WORD_W), .BYTES(BYTES), .IDLE_LIMIT(IDLE_LIMIT),
  .CNT_W(CNT_W), .IDLE_W(IDLE_W)
) u_chk (
  .clk_i, .rst_ni, .cap_edge, .valid_o, .i_word_o, .q_word_o,
  .byte_cnt, .idle_cnt
);

// File: tb/gclk_sample_rx_test.sv
module gclk_sample_rx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fclk_i = 1'b0;
  logic [7:0]  fdata_i = '0;
  logic [23:0] i_word_o, q_word_o;
  logic        valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  gclk_sample_rx uut (
    .clk_i, .rst_ni, .fclk_i, .fdata_i, .i_word_o, .q_word_o, .valid_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one forwarded-clock period; hi = receiver cycles with fclk high (>=2)
  task automatic send_byte(input logic [7:0] b, input int hi, input bit last,
                           input logic [23:0] ei, input logic [23:0] eq,
                           input string req);
    fdata_i = b;
    fclk_i  = 1'b1;
    for (int n = 1; n <= hi + 2; n++) begin
      @(negedge clk_i);
      if (n == hi) fclk_i = 1'b0;
      if (n == 3) begin
        chk(valid_o === last, req, "valid at third edge", {47'd0, valid_o}, {47'd0, last});
        if (last) chk({i_word_o, q_word_o} === {ei, eq}, req, "I/Q words",
                      {i_word_o, q_word_o}, {ei, eq});
      end
      if (n == 4 && last) begin
        chk(valid_o === 1'b0, "R5", "pulse ended", {47'd0, valid_o}, 48'd0);
        chk({i_word_o, q_word_o} === {ei, eq}, "R6", "words held",
            {i_word_o, q_word_o}, {ei, eq});
      end
    end
  endtask

  task automatic gap(input int cyc, input bit noise);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk_i);
      if (noise) fdata_i = 8'(c * 37 + 11);
    end
  endtask

  task automatic send_pair(input logic [23:0] iw, input logic [23:0] qw,
                           input int noise_gap, input int long_hi, input string req);
    logic [47:0] all;
    all = {iw, qw};
    for (int k = 0; k < 6; k++) begin
      send_byte(all[47-8*k -: 8], (k == 1 && long_hi > 0) ? long_hi : 2,
                k == 5, iw, qw, req);
      if (noise_gap > 0 && k < 5) gap(noise_gap, 1'b1);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk({valid_o, i_word_o, q_word_o} === 49'd0, "R1", "outputs in reset",
        {i_word_o, q_word_o}, 48'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({valid_o, i_word_o, q_word_o} === 49'd0, "R1", "outputs after reset",
        {i_word_o, q_word_o}, 48'd0);
  endtask

  task automatic t_basic;       // R3 R4 R5
    send_pair(24'h123456, 24'hABCDEF, 0, 0, "R4");
  endtask

  task automatic t_stream;      // R9
    send_pair(24'hA5A5A5, 24'h5A5A5A, 0, 0, "R9");
    send_pair(24'hFFFFFF, 24'h000000, 0, 0, "R9");
    send_pair(24'h00FF01, 24'h80017F, 0, 0, "R3");
  endtask

  task automatic t_noise;       // R2, gaps below the idle limit (R7)
    send_pair(24'hC0FFEE, 24'h0BEEF0, 7, 0, "R2");
  endtask

  task automatic t_long_high;   // R8
    send_pair(24'h13579B, 24'h2468AC, 0, 10, "R8");
  endtask

  task automatic t_timeout;     // R7
    send_byte(8'hDE, 2, 1'b0, '0, '0, "R7");
    send_byte(8'hAD, 2, 1'b0, '0, '0, "R7");
    gap(60, 1'b0);
    send_pair(24'h654321, 24'hFEDCBA, 0, 0, "R7");
  endtask

  task automatic t_hold;        // R6
    gap(25, 1'b1);
    chk(valid_o === 1'b0, "R6", "no pulse while idle", {47'd0, valid_o}, 48'd0);
    chk({i_word_o, q_word_o} === {24'h654321, 24'hFEDCBA}, "R6", "words hold idle",
        {i_word_o, q_word_o}, {24'h654321, 24'hFEDCBA});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stream();
    t_noise();
    t_long_high();
    t_timeout();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule